// File: doc/BRIEF.md
# Five-Stage Pipelined Integer Core with Decode-Stage Bypassing

This block is a 32-bit in-order integer core with five pipeline stages: fetch, decode, execute, memory and writeback. It runs a small load/store instruction subset: the register-to-register operations add, subtract, AND, OR and XOR, plus word load and word store. The instruction store and the data store are internal word arrays. A testbench fills them before it releases reset. The only observable outputs are the program counter and a combinational read port on the register file, which is used for debug.

Data hazards are resolved in the decode stage. Each source operand is picked from one of three places: the value the execute stage is computing in the current cycle, the value leaving the memory stage, or the register file. The register file is written on the falling clock edge, so a result in writeback can be read by decode during the second half of the same cycle. The only case that bypassing cannot cover is a load whose result is needed by the instruction directly behind it. For that case the core holds fetch and decode for one cycle and sends an empty slot into execute.

Top module: `pipe5_core`

## Requirements
- R1: While reset is low, the program counter reads 0 and every register reads 0 through the debug port. After reset, the program counter rises by 4 on each clock edge unless a load-use stall holds it. Instruction words are fetched from word index pc[7:2].
- R2: An R-type word has opcode bits[31:26]=0, rs in bits[25:21], rt in bits[20:16] and rd in bits[15:11]. Its function field bits[5:0] selects the operation: 0x20 writes rs+rt, 0x22 writes rs-rt, 0x24 writes rs AND rt, 0x25 writes rs OR rt, and 0x26 writes rs XOR rt, each into rd.
- R3: A chain of dependent R-type operations, each reading the previous result, runs with no stall cycle and gives architecturally correct values.
- R4: When two older instructions in flight both target a source register, the operand takes the younger one's value. The execute-stage result wins over the memory-stage value, and the memory-stage value wins over the register file.
- R5: An instruction that reads a register three instructions after that register was written gets the new value, because writeback and decode share the cycle.
- R6: A load has opcode 0x23. It writes the data word at byte address rs + sign-extended bits[15:0] into rt. Negative offsets work. The data word index is address bits[7:2].
- R7: A store has opcode 0x2B. It writes rt to the data word at rs + sign-extended offset and changes no register. A load that follows it reads the stored value.
- R8: A load followed directly by an instruction that reads the load's destination (rs for any supported instruction; rt for R-type and store) holds the program counter for exactly one cycle. The results stay correct.
- R9: Register 0 always reads as 0. Writes to it are dropped, and a pending write to it is never bypassed.
- R10: The debug port returns the addressed register combinationally.
- R11: Any encoding other than the seven listed above writes no register and no memory, and never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pipeline registers update on the rising edge, the register file on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_o | output | 32 | Current fetch address |
| dbg_addr | input | 5 | Register index for debug read |
| dbg_data | output | 32 | Contents of the addressed register |

## Verification
The arithmetic chain takes the five-instruction dependent sequence with its operands loaded from memory. A result that went through the register file instead of being bypassed would expose a missing execute-stage or memory-stage path, and a stalled program counter would expose an unneeded stall. A second program writes the same register twice in a row and then reads it. This separates correct priority from reversed priority. The same program writes register 0 and then reads it, and places a reader exactly three slots after a writer, which checks the falling-edge write. A third program chains loads, stores with negative offsets and load-use pairs on both source fields, so the program counter is compared against a model that predicts each hold cycle. A last program feeds undefined encodings right behind a load, which tells a correct decoder apart from one that writes registers or stalls on them.

// File: rtl/core_pkg.sv
package core_pkg;

  localparam int XLEN = 32;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4
  } alu_op_e;

  typedef struct packed {
    logic    wr;        // writes a register
    logic    m2reg;     // register value comes from data memory
    logic    wmem;      // writes data memory
    logic    alusrc;    // second ALU operand is the immediate
    alu_op_e op;
    logic    use_rs;
    logic    use_rt;
    logic    rd_is_rt;  // destination field is bits 20:16
  } ctrl_t;

  function automatic logic [XLEN-1:0] alu_eval(alu_op_e op, logic [XLEN-1:0] a,
                                                logic [XLEN-1:0] b);
    case (op)
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_XOR: return a ^ b;
      default: return a + b;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] sext16(logic [15:0] v);
    return {{(XLEN-16){v[15]}}, v};
  endfunction

  function automatic ctrl_t decode(logic [31:0] inst);
    ctrl_t c;
    c = '0;
    c.op = ALU_ADD;
    case (inst[31:26])
      6'h00: begin
        c.use_rs = 1'b1;
        c.use_rt = 1'b1;
        c.wr     = 1'b1;
        case (inst[5:0])
          6'h20: c.op = ALU_ADD;
          6'h22: c.op = ALU_SUB;
          6'h24: c.op = ALU_AND;
          6'h25: c.op = ALU_OR;
          6'h26: c.op = ALU_XOR;
          default: c = '0;
        endcase
      end
      6'h23: begin
        c.wr = 1'b1; c.m2reg = 1'b1; c.alusrc = 1'b1;
        c.use_rs = 1'b1; c.rd_is_rt = 1'b1;
      end
      6'h2B: begin
        c.wmem = 1'b1; c.alusrc = 1'b1;
        c.use_rs = 1'b1; c.use_rt = 1'b1;
      end
      default: c = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int NREG = 32,
  localparam int RAW = $clog2(NREG)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [RAW-1:0]             wa,
  input  logic [core_pkg::XLEN-1:0]  wd,
  input  logic [RAW-1:0]             ra1,
  input  logic [RAW-1:0]             ra2,
  input  logic [RAW-1:0]             ra3,
  output logic [core_pkg::XLEN-1:0]  rd1,
  output logic [core_pkg::XLEN-1:0]  rd2,
  output logic [core_pkg::XLEN-1:0]  rd3
);
  logic [core_pkg::XLEN-1:0] regs [NREG];

  // Written on the falling edge so decode sees the value in the same cycle.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && (wa != '0)) begin
      regs[wa] <= wd;
    end
  end

  assign rd1 = regs[ra1];
  assign rd2 = regs[ra2];
  assign rd3 = regs[ra3];

  // R9: register 0 holds zero
  p_zero_reg_r9: assert property (@(posedge clk) disable iff (!rst_n)
    regs[0] == '0);

  // R5: a value written this cycle is visible to the read ports by the next rising edge
  p_wb_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (wa != '0) && (ra1 == wa)) |-> (rd1 == wd));

endmodule

// File: rtl/core_bypass.sv
module core_bypass #(
  parameter int RAW = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [RAW-1:0]             src,
  input  logic [core_pkg::XLEN-1:0]  rf_val,
  input  logic                       ex_wr,
  input  logic                       ex_load,
  input  logic [RAW-1:0]             ex_rd,
  input  logic [core_pkg::XLEN-1:0]  ex_val,
  input  logic                       mem_wr,
  input  logic [RAW-1:0]             mem_rd,
  input  logic [core_pkg::XLEN-1:0]  mem_val,
  output logic [core_pkg::XLEN-1:0]  opnd,
  output logic                       load_hit
);
  logic ex_match, mem_match;

  assign ex_match  = ex_wr  && (ex_rd  != '0) && (ex_rd  == src);
  assign mem_match = mem_wr && (mem_rd != '0) && (mem_rd == src);

  always_comb begin
    load_hit = 1'b0;
    opnd     = rf_val;
    if (ex_match) begin
      if (ex_load) load_hit = 1'b1;
      else         opnd = ex_val;
    end else if (mem_match) begin
      opnd = mem_val;
    end
  end

  // R9: a source of register 0 always yields zero
  p_bypass_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (opnd == '0));

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core #(
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6,
  parameter int NREG    = 32,
  localparam int RAW        = $clog2(NREG),
  localparam int IMEM_WORDS = 1 << IMEM_AW,
  localparam int DMEM_WORDS = 1 << DMEM_AW
) (
  input  logic                       clk,
  input  logic                       rst_n,
  output logic [core_pkg::XLEN-1:0]  pc_o,
  input  logic [RAW-1:0]             dbg_addr,
  output logic [core_pkg::XLEN-1:0]  dbg_data
);
  import core_pkg::*;

  // Instruction and data stores, filled by the environment before reset release.
  logic [31:0]     imem [IMEM_WORDS];
  logic [XLEN-1:0] dmem [DMEM_WORDS];

  initial begin
    for (int i = 0; i < IMEM_WORDS; i++) imem[i] = '0;
    for (int i = 0; i < DMEM_WORDS; i++) dmem[i] = '0;
  end

  // ---------------- fetch ----------------
  logic [XLEN-1:0] pc_q;
  logic [31:0]     f_inst;
  logic            stall;

  assign f_inst = imem[pc_q[IMEM_AW+1:2]];
  assign pc_o   = pc_q;

  // ---------------- decode ----------------
  logic [31:0]     d_inst;
  ctrl_t           d_ctrl;
  logic [RAW-1:0]  d_rs, d_rt, d_rd;
  logic [XLEN-1:0] d_imm;
  logic [XLEN-1:0] rf_a, rf_b;
  logic [XLEN-1:0] d_opnd [2];
  logic            d_lhit [2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      d_inst <= '0;
    end else if (!stall) begin
      pc_q   <= pc_q + XLEN'(4);
      d_inst <= f_inst;
    end
  end

  assign d_ctrl = decode(d_inst);
  assign d_rs   = RAW'(d_inst[25:21]);
  assign d_rt   = RAW'(d_inst[20:16]);
  assign d_rd   = d_ctrl.rd_is_rt ? d_rt : RAW'(d_inst[15:11]);
  assign d_imm  = sext16(d_inst[15:0]);

  // ---------------- later-stage state ----------------
  ctrl_t           e_ctrl;
  logic [XLEN-1:0] e_a, e_b, e_imm, e_bsrc, e_alu;
  logic [RAW-1:0]  e_rd;

  ctrl_t           m_ctrl;
  logic [XLEN-1:0] m_alu, m_sd, m_load, m_val;
  logic [RAW-1:0]  m_rd;
  logic [DMEM_AW-1:0] m_addr;

  logic            w_wr;
  logic [RAW-1:0]  w_rd;
  logic [XLEN-1:0] w_val;

  core_regfile #(.NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .we(w_wr), .wa(w_rd), .wd(w_val),
    .ra1(d_rs), .ra2(d_rt), .ra3(dbg_addr),
    .rd1(rf_a), .rd2(rf_b), .rd3(dbg_data)
  );

  // One bypass selector per source operand.
  generate
    for (genvar k = 0; k < 2; k++) begin : g_byp
      core_bypass #(.RAW(RAW)) u_byp (
        .clk(clk), .rst_n(rst_n),
        .src     (k == 0 ? d_rs : d_rt),
        .rf_val  (k == 0 ? rf_a : rf_b),
        .ex_wr   (e_ctrl.wr),
        .ex_load (e_ctrl.m2reg),
        .ex_rd   (e_rd),
        .ex_val  (e_alu),
        .mem_wr  (m_ctrl.wr),
        .mem_rd  (m_rd),
        .mem_val (m_val),
        .opnd    (d_opnd[k]),
        .load_hit(d_lhit[k])
      );
    end
  endgenerate

  assign stall = (d_lhit[0] && d_ctrl.use_rs) || (d_lhit[1] && d_ctrl.use_rt);

  // ---------------- decode -> execute ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_ctrl <= '0;
      e_a <= '0; e_b <= '0; e_imm <= '0; e_rd <= '0;
    end else if (stall) begin
      e_ctrl <= '0;
      e_rd   <= '0;
    end else begin
      e_ctrl <= d_ctrl;
      e_a    <= d_opnd[0];
      e_b    <= d_opnd[1];
      e_imm  <= d_imm;
      e_rd   <= d_rd;
    end
  end

  assign e_bsrc = e_ctrl.alusrc ? e_imm : e_b;
  assign e_alu  = alu_eval(e_ctrl.op, e_a, e_bsrc);

  // ---------------- execute -> memory ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0;
      m_alu <= '0; m_sd <= '0; m_rd <= '0;
    end else begin
      m_ctrl <= e_ctrl;
      m_alu  <= e_alu;
      m_sd   <= e_b;
      m_rd   <= e_rd;
    end
  end

  assign m_addr = m_alu[DMEM_AW+1:2];
  assign m_load = dmem[m_addr];
  assign m_val  = m_ctrl.m2reg ? m_load : m_alu;

  always @(posedge clk) begin
    if (rst_n && m_ctrl.wmem) dmem[m_addr] <= m_sd;
  end

  // ---------------- memory -> writeback ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_wr <= 1'b0; w_rd <= '0; w_val <= '0;
    end else begin
      w_wr  <= m_ctrl.wr;
      w_rd  <= m_rd;
      w_val <= m_val;
    end
  end

  // ---------------- assertions ----------------
  // R1: program counter steps by one word when not held
  p_pc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !stall |=> (pc_q == $past(pc_q) + XLEN'(4)));

  // R8: a stall holds fetch and sends an empty slot into execute
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(pc_q) && !e_ctrl.wr && !e_ctrl.wmem));

  // R8: a load-use hold lasts a single cycle
  p_stall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

  // R2: subtraction result plus subtrahend restores the minuend
  p_sub_inverse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (e_ctrl.op == ALU_SUB) |-> ((e_alu + e_bsrc) == e_a));

  // R7: a store in memory stage never carries a register write
  p_store_noreg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    m_ctrl.wmem |-> !m_ctrl.wr);

endmodule

// File: tb/test_pipe5_core.sv
`timescale 1ns/1ps
module test_pipe5_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pc_o;
  logic [4:0]  dbg_addr = '0;
  logic [31:0] dbg_data;

  int n_checks = 0;
  int n_fail   = 0;

  pipe5_core i_pipe5_core (.clk(clk), .rst_n(rst_n), .pc_o(pc_o),
                           .dbg_addr(dbg_addr), .dbg_data(dbg_data));

  always #4 clk = ~clk;  // 125 MHz

  // program and data image for the current test
  logic [31:0] prog  [64];
  logic [31:0] dinit [64];
  int          plen;

  // cycle model state
  logic [31:0] mdl_pc, mdl_id, mdl_ex;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rt_op(int fn, int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction
  function automatic logic [31:0] i_op(int op, int rt, int rs, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  function automatic bit known_r(logic [31:0] w);
    return (w[31:26] == 0) && (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h26});
  endfunction
  function automatic bit reads_rs(logic [31:0] w);
    return known_r(w) || w[31:26] == 6'h23 || w[31:26] == 6'h2B;
  endfunction
  function automatic bit reads_rt(logic [31:0] w);
    return known_r(w) || w[31:26] == 6'h2B;
  endfunction

  // Sequential instruction-set interpreter giving final register values.
  task automatic iss(output logic [31:0] r [32]);
    logic [31:0] m [64];
    for (int i = 0; i < 32; i++) r[i] = 0;
    for (int i = 0; i < 64; i++) m[i] = dinit[i];
    for (int i = 0; i < plen; i++) begin
      logic [31:0] w, a, b, res, ea;
      int rs, rt, rd;
      w = prog[i]; rs = w[25:21]; rt = w[20:16]; rd = w[15:11];
      a = r[rs]; b = r[rt];
      ea = a + {{16{w[15]}}, w[15:0]};
      if (known_r(w)) begin
        case (w[5:0])
          6'h20: res = a + b;
          6'h22: res = a - b;
          6'h24: res = a & b;
          6'h25: res = a | b;
          default: res = a ^ b;
        endcase
        if (rd != 0) r[rd] = res;
      end else if (w[31:26] == 6'h23) begin
        if (rt != 0) r[rt] = m[ea[7:2]];
      end else if (w[31:26] == 6'h2B) begin
        m[ea[7:2]] = b;
      end
    end
  endtask

  task automatic run_prog(input string rtag, input int ncyc);
    logic [31:0] expr [32];
    rst_n = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      i_pipe5_core.imem[i] = (i < plen) ? prog[i] : 32'h0;
      i_pipe5_core.dmem[i] = dinit[i];
    end
    @(negedge clk);
    check(pc_o == 0, "R1", "pc in reset", pc_o, 0);
    dbg_addr = 5'd3; #1;
    check(dbg_data == 0, "R1", "reg3 in reset", dbg_data, 0);
    @(negedge clk);
    rst_n = 1'b1;
    mdl_pc = 0; mdl_id = 0; mdl_ex = 0;
    for (int c = 0; c < ncyc; c++) begin
      bit hz;
      @(posedge clk);
      hz = (mdl_ex[31:26] == 6'h23) && (mdl_ex[20:16] != 0) &&
           ((reads_rs(mdl_id) && mdl_id[25:21] == mdl_ex[20:16]) ||
            (reads_rt(mdl_id) && mdl_id[20:16] == mdl_ex[20:16]));
      if (hz) mdl_ex = 0;
      else begin
        mdl_ex = mdl_id;
        mdl_id = (mdl_pc[31:2] < 30'(plen)) ? prog[mdl_pc[7:2]] : 32'h0;
        mdl_pc = mdl_pc + 4;
      end
      @(negedge clk);
      check(pc_o == mdl_pc, hz ? "R8" : "R3", "pc per cycle", pc_o, mdl_pc);
    end
    iss(expr);
    for (int r = 0; r < 32; r++) begin
      dbg_addr = 5'(r); #1;
      check(dbg_data == expr[r], rtag, $sformatf("reg%0d", r), dbg_data, expr[r]);
    end
  endtask

  task automatic clear_image();
    for (int i = 0; i < 64; i++) begin prog[i] = 0; dinit[i] = 0; end
  endtask

  initial begin
    #(8 * 20000);
    n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // Program A: dependent arithmetic chain (R2, R3)
    clear_image();
    dinit[0] = 32'h0000_1234; dinit[1] = 32'h0FF0_00F1; dinit[2] = 32'h8000_5A5A;
    prog[0] = i_op(6'h23, 1, 0, 0);
    prog[1] = i_op(6'h23, 2, 0, 4);
    prog[2] = i_op(6'h23, 9, 0, 8);
    prog[3] = 32'h00221820;
    prog[4] = 32'h01232022;
    prog[5] = 32'h00692825;
    prog[6] = 32'h00693026;
    prog[7] = 32'h00693824;
    plen = 8;
    run_prog("R2", 2 * plen + 8);
    // R10: debug read follows the address with no clock
    dbg_addr = 5'd4; #1;
    check(dbg_data == 32'h8000_5A5A - 32'h0FF0_1325, "R10", "dbg reg4", dbg_data,
          32'h8000_5A5A - 32'h0FF0_1325);
    dbg_addr = 5'd6; #1;
    check(dbg_data == (32'h0FF0_1325 ^ 32'h8000_5A5A), "R10", "dbg reg6", dbg_data,
          32'h0FF0_1325 ^ 32'h8000_5A5A);

    // Program B: priority, register 0, writeback/decode sharing (R4, R5, R9)
    clear_image();
    dinit[0] = 32'h11; dinit[1] = 32'h100;
    prog[0]  = i_op(6'h23, 1, 0, 0);
    prog[1]  = i_op(6'h23, 2, 0, 4);
    prog[2]  = 32'h0;
    prog[3]  = rt_op(6'h20, 5, 1, 1);
    prog[4]  = rt_op(6'h20, 5, 5, 2);
    prog[5]  = rt_op(6'h20, 6, 5, 5);
    prog[6]  = rt_op(6'h20, 0, 1, 2);
    prog[7]  = rt_op(6'h20, 7, 0, 1);
    prog[8]  = rt_op(6'h20, 8, 1, 2);
    prog[9]  = 32'h0;
    prog[10] = 32'h0;
    prog[11] = rt_op(6'h20, 10, 8, 8);
    plen = 12;
    run_prog("R4", 2 * plen + 8);
    dbg_addr = 5'd6; #1;
    check(dbg_data == 32'h244, "R4", "younger writer wins", dbg_data, 32'h244);
    dbg_addr = 5'd7; #1;
    check(dbg_data == 32'h11, "R9", "no bypass from reg0", dbg_data, 32'h11);
    dbg_addr = 5'd0; #1;
    check(dbg_data == 32'h0, "R9", "reg0 stays zero", dbg_data, 32'h0);
    dbg_addr = 5'd10; #1;
    check(dbg_data == 32'h222, "R5", "same-cycle writeback read", dbg_data, 32'h222);

    // Program C: loads, stores, load-use holds (R6, R7, R8)
    clear_image();
    dinit[0] = 32'h7; dinit[1] = 32'hA; dinit[3] = 32'h20;
    prog[0] = i_op(6'h23, 1, 0, 0);
    prog[1] = rt_op(6'h20, 2, 1, 1);
    prog[2] = i_op(6'h23, 3, 0, 12);
    prog[3] = i_op(6'h2B, 2, 3, -8);
    prog[4] = i_op(6'h23, 4, 3, -8);
    prog[5] = i_op(6'h23, 5, 0, 4);
    prog[6] = i_op(6'h2B, 5, 0, 0);
    prog[7] = i_op(6'h23, 6, 0, 0);
    prog[8] = rt_op(6'h26, 13, 6, 4);
    plen = 9;
    run_prog("R6", 2 * plen + 8);
    dbg_addr = 5'd4; #1;
    check(dbg_data == 32'hE, "R7", "store then load back", dbg_data, 32'hE);
    dbg_addr = 5'd13; #1;
    check(dbg_data == 32'h4, "R8", "load-use result", dbg_data, 32'h4);

    // Program D: undefined encodings (R11)
    clear_image();
    dinit[0] = 32'h55;
    prog[0] = i_op(6'h23, 1, 0, 0);
    prog[1] = rt_op(6'h2A, 13, 1, 1);
    prog[2] = i_op(6'h08, 12, 1, 5);
    prog[3] = 32'hFFFF_FFFF;
    prog[4] = rt_op(6'h20, 14, 1, 0);
    plen = 5;
    run_prog("R11", 2 * plen + 8);
    dbg_addr = 5'd12; #1;
    check(dbg_data == 32'h0, "R11", "undefined op no write", dbg_data, 32'h0);
    dbg_addr = 5'd14; #1;
    check(dbg_data == 32'h55, "R11", "core continues", dbg_data, 32'h55);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule